// File: doc/BRIEF.md
# Cross-Processor Interrupt Flag Controller

This block sits between a host processor and a coprocessor and keeps the interrupt flags that each side raises toward the other. Both sides reach it over one byte-wide write port. Each side has four registers: a control register that raises flags and leaves a 4-bit message, an enable register, a clear register, and a flag status byte that is always visible on an output. Two event inputs from the timer and DMA engines raise coprocessor flags. A character-DMA completion input raises a host flag. Each event input is a one-cycle pulse.

The coprocessor IRQ and NMI outputs follow their flags and enables directly. The host IRQ output is a latched line. It is set when an enabled host flag is raised, or when a host enable is switched on while its flag is already pending. It is released only by a clear write that leaves both host flags empty. Disabling a source does not release it. All state changes on the rising clock edge, and a synchronous active-high reset returns every flag, enable, message and output to zero.

Write register select codes on `wr_addr`: 0 coprocessor control, 1 host enable, 2 host clear, 3 host control, 4 coprocessor enable, 5 coprocessor clear.

Top module: `ipc_irq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every flag, enable, message and vector-switch bit is cleared. After that edge `host_status`, `cop_status`, `host_irq`, `cop_irq` and `cop_nmi` all read zero.
- R2: A write to select 0 (coprocessor control) affects flags and the message as follows. Bit 7 set raises the coprocessor IRQ flag. Bit 4 set raises the coprocessor NMI flag. Bits 3:0 replace the coprocessor message. A zero in bit 7 or bit 4 leaves the matching flag unchanged.
- R3: A write to select 3 (host control) with bit 7 set raises the host IRQ flag. Bits 6 and 4 replace the IRQ and NMI vector-switch bits, and bits 3:0 replace the host message. A zero in bit 7 leaves the flag unchanged.
- R4: The `host_status` byte has this layout: bit 7 host IRQ flag, bit 6 IRQ vector switch, bit 5 character-DMA flag, bit 4 NMI vector switch, bits 3:0 host message.
- R5: The `cop_status` byte has this layout: bit 7 coprocessor IRQ flag, bit 6 timer flag, bit 5 DMA flag, bit 4 NMI flag, bits 3:0 coprocessor message.
- R6: A pulse on `chdma_done`, `timer_evt` or `dma_evt` raises the character-DMA, timer or DMA flag on the following edge. If a clear write for the same flag arrives in the same cycle, the raise wins.
- R7: A write of 1 to a bit of a clear register clears the matching flag. For select 2 (host clear), bit 7 is the IRQ flag and bit 5 is the character-DMA flag. For select 5 (coprocessor clear), bits 7, 6, 5 and 4 are the IRQ, timer, DMA and NMI flags. A 0 bit has no effect.
- R8: When a host flag is raised while its enable is already set, `host_irq` is high after that edge. Select 1 bit 7 enables the host IRQ flag and bit 5 enables the character-DMA flag.
- R9: A raise with the enable off leaves `host_irq` low. Turning the enable from 0 to 1 while the flag is pending sets `host_irq` on that edge.
- R10: Once set, `host_irq` stays high until a host clear write leaves both host flags clear. Clearing only one flag keeps it high, and so does writing the enables to zero.
- R11: `cop_irq` is high exactly when the IRQ, timer or DMA flag is set together with its enable. Select 4 bits 7, 6 and 5 are those enables. `cop_nmi` is the NMI flag ANDed with select 4 bit 4. Enabling a pending flag therefore asserts the output after that edge.
- R12: A write to an enable register replaces all of its enable bits with the written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for one register per cycle |
| wr_addr | input | 3 | Register select code |
| wr_data | input | 8 | Write data byte |
| chdma_done | input | 1 | Character-DMA completion pulse |
| timer_evt | input | 1 | Timer event pulse |
| dma_evt | input | 1 | DMA completion pulse |
| host_status | output | 8 | Host-side flag status byte |
| cop_status | output | 8 | Coprocessor-side flag status byte |
| host_irq | output | 1 | Latched interrupt line to the host |
| cop_irq | output | 1 | Interrupt request to the coprocessor |
| cop_nmi | output | 1 | Non-maskable interrupt to the coprocessor |

## Verification
Flags are raised in three ways: with their enables off, with them already on, and by switching an enable on over a pending flag. The first case separates flag storage from output drive. The other two separate the plain raise path from the re-arm path. On the host side, the two flags are cleared one at a time, and the enables are switched off in between. This shows that the line is a latch released only by the last clear and not a gated copy of the flags. Control writes with zero flag bits, all-zero clear writes, and an event pulse coinciding with a clear of the same flag check that nothing is lost or cleared by accident. A reset in the middle of the run confirms that the idle state can be reached again.

// File: rtl/ipc_irq_pkg.sv
package ipc_irq_pkg;

   // write register select codes
   localparam logic [2:0] SEL_COP_CTRL  = 3'd0;
   localparam logic [2:0] SEL_HOST_EN   = 3'd1;
   localparam logic [2:0] SEL_HOST_CLR  = 3'd2;
   localparam logic [2:0] SEL_HOST_CTRL = 3'd3;
   localparam logic [2:0] SEL_COP_EN    = 3'd4;
   localparam logic [2:0] SEL_COP_CLR   = 3'd5;

   // host-side bit positions (control, enable, clear and status share them)
   localparam int HB_IRQ   = 7;
   localparam int HB_IVSW  = 6;
   localparam int HB_CHDMA = 5;
   localparam int HB_NVSW  = 4;

   // coprocessor-side bit positions
   localparam int CB_IRQ   = 7;
   localparam int CB_TIMER = 6;
   localparam int CB_DMA   = 5;
   localparam int CB_NMI   = 4;

   // flag bank indices
   localparam int HOST_NFLAG = 2;   // [1]=irq, [0]=chdma
   localparam int COP_NFLAG  = 4;   // [3]=irq, [2]=timer, [1]=dma, [0]=nmi

   localparam int MSG_MAX = 4;

endpackage

// File: rtl/ipc_flag_bank.sv
module ipc_flag_bank #(
   parameter int N        = 2,
   parameter bit SET_WINS = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] set_vec,
   input  logic [N-1:0] clr_vec,
   input  logic         en_we,
   input  logic [N-1:0] en_wdata,
   output logic [N-1:0] flag,
   output logic [N-1:0] en
);

   logic [N-1:0] flag_nxt;

   if (N < 1) begin : g_bad_n
      $error("ipc_flag_bank: N must be at least 1");
   end

   generate
      if (SET_WINS) begin : g_set_wins
         assign flag_nxt = set_vec | (flag & ~clr_vec);
      end else begin : g_clr_wins
         assign flag_nxt = (set_vec | flag) & ~clr_vec;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         flag <= '0;
         en   <= '0;
      end else begin
         flag <= flag_nxt;
         if (en_we) en <= en_wdata;
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_chk
      // R6: a raise lands on the next edge (unless a clear-priority variant overrides)
      p_raise_lands_r6: assert property (@(posedge clk) disable iff (rst)
         set_vec[i] && (SET_WINS || !clr_vec[i]) |=> flag[i]);
      // R7: a clear without a coinciding raise empties the flag
      p_clear_lands_r7: assert property (@(posedge clk) disable iff (rst)
         clr_vec[i] && !set_vec[i] |=> !flag[i]);
      // R7: without raise or clear the flag holds
      p_flag_holds_r7: assert property (@(posedge clk) disable iff (rst)
         !clr_vec[i] && !set_vec[i] |=> $stable(flag[i]));
      // R12: enables change only on an enable write
      p_en_holds_r12: assert property (@(posedge clk) disable iff (rst)
         !en_we |=> $stable(en[i]));
   end

endmodule

// File: rtl/ipc_host_line.sv
module ipc_host_line #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] set_vec,
   input  logic [N-1:0] flag,
   input  logic [N-1:0] en,
   input  logic         en_we,
   input  logic [N-1:0] en_wdata,
   input  logic         clr_we,
   input  logic [N-1:0] clr_vec,
   output logic         line
);

   logic [N-1:0] en_rise;
   logic [N-1:0] remain;
   logic         raise;
   logic         drop;

   always_comb begin
      en_rise = en_we ? (en_wdata & ~en) : '0;
      raise   = (|(set_vec & en)) | (|(en_rise & (flag | set_vec)));
      remain  = (flag & ~clr_vec) | set_vec;
      drop    = clr_we & ~(|remain);
   end

   always_ff @(posedge clk) begin
      if (rst)        line <= 1'b0;
      else if (raise) line <= 1'b1;
      else if (drop)  line <= 1'b0;
   end

   // R8: an enabled raise sets the line
   p_enabled_raise_r8: assert property (@(posedge clk) disable iff (rst)
      |(set_vec & en) |=> line);
   // R9: switching an enable on over a pending flag sets the line
   p_rearm_r9: assert property (@(posedge clk) disable iff (rst)
      en_we && |(en_wdata & ~en & flag) |=> line);
   // R10: without a clear write the line never falls
   p_hold_r10: assert property (@(posedge clk) disable iff (rst)
      line && !clr_we |=> line);

endmodule

// File: rtl/ipc_irq_ctrl.sv
module ipc_irq_ctrl
   import ipc_irq_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 3,
   parameter int MSG_W    = 4,
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              chdma_done,
   input  logic              timer_evt,
   input  logic              dma_evt,
   output logic [DATA_W-1:0] host_status,
   output logic [DATA_W-1:0] cop_status,
   output logic              host_irq,
   output logic              cop_irq,
   output logic              cop_nmi
);

   localparam int HN = HOST_NFLAG;
   localparam int CN = COP_NFLAG;

   if (DATA_W < 8) begin : g_bad_data
      $error("ipc_irq_ctrl: DATA_W must be at least 8");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ipc_irq_ctrl: ADDR_W must be at least 3");
   end
   if (MSG_W < 1 || MSG_W > MSG_MAX) begin : g_bad_msg
      $error("ipc_irq_ctrl: MSG_W out of range");
   end

   // ---------------- write decode ----------------
   logic we_cop_ctrl, we_host_en, we_host_clr, we_host_ctrl, we_cop_en, we_cop_clr;

   always_comb begin
      we_cop_ctrl  = wr_en && (wr_addr == ADDR_W'(SEL_COP_CTRL));
      we_host_en   = wr_en && (wr_addr == ADDR_W'(SEL_HOST_EN));
      we_host_clr  = wr_en && (wr_addr == ADDR_W'(SEL_HOST_CLR));
      we_host_ctrl = wr_en && (wr_addr == ADDR_W'(SEL_HOST_CTRL));
      we_cop_en    = wr_en && (wr_addr == ADDR_W'(SEL_COP_EN));
      we_cop_clr   = wr_en && (wr_addr == ADDR_W'(SEL_COP_CLR));
   end

   // ---------------- host side ----------------
   logic [HN-1:0] h_set, h_clr, h_en_wd, h_flag, h_en;

   always_comb begin
      h_set   = {we_host_ctrl & wr_data[HB_IRQ], chdma_done};
      h_clr   = we_host_clr ? {wr_data[HB_IRQ], wr_data[HB_CHDMA]} : '0;
      h_en_wd = {wr_data[HB_IRQ], wr_data[HB_CHDMA]};
   end

   ipc_flag_bank #(.N(HN), .SET_WINS(SET_WINS)) u_host_bank (
      .clk      (clk),
      .rst      (rst),
      .set_vec  (h_set),
      .clr_vec  (h_clr),
      .en_we    (we_host_en),
      .en_wdata (h_en_wd),
      .flag     (h_flag),
      .en       (h_en)
   );

   ipc_host_line #(.N(HN)) u_host_line (
      .clk      (clk),
      .rst      (rst),
      .set_vec  (h_set),
      .flag     (h_flag),
      .en       (h_en),
      .en_we    (we_host_en),
      .en_wdata (h_en_wd),
      .clr_we   (we_host_clr),
      .clr_vec  (h_clr),
      .line     (host_irq)
   );

   logic             h_ivsw, h_nvsw;
   logic [MSG_W-1:0] h_msg;

   always_ff @(posedge clk) begin
      if (rst) begin
         h_ivsw <= 1'b0;
         h_nvsw <= 1'b0;
         h_msg  <= '0;
      end else if (we_host_ctrl) begin
         h_ivsw <= wr_data[HB_IVSW];
         h_nvsw <= wr_data[HB_NVSW];
         h_msg  <= wr_data[MSG_W-1:0];
      end
   end

   // ---------------- coprocessor side ----------------
   logic [CN-1:0] c_set, c_clr, c_en_wd, c_flag, c_en;

   always_comb begin
      c_set   = {we_cop_ctrl & wr_data[CB_IRQ], timer_evt, dma_evt,
                 we_cop_ctrl & wr_data[CB_NMI]};
      c_clr   = we_cop_clr ? {wr_data[CB_IRQ], wr_data[CB_TIMER],
                              wr_data[CB_DMA], wr_data[CB_NMI]} : '0;
      c_en_wd = {wr_data[CB_IRQ], wr_data[CB_TIMER], wr_data[CB_DMA], wr_data[CB_NMI]};
   end

   ipc_flag_bank #(.N(CN), .SET_WINS(SET_WINS)) u_cop_bank (
      .clk      (clk),
      .rst      (rst),
      .set_vec  (c_set),
      .clr_vec  (c_clr),
      .en_we    (we_cop_en),
      .en_wdata (c_en_wd),
      .flag     (c_flag),
      .en       (c_en)
   );

   logic [MSG_W-1:0] c_msg;

   always_ff @(posedge clk) begin
      if (rst)              c_msg <= '0;
      else if (we_cop_ctrl) c_msg <= wr_data[MSG_W-1:0];
   end

   always_comb begin
      cop_irq = |(c_flag[CN-1:1] & c_en[CN-1:1]);
      cop_nmi = c_flag[0] & c_en[0];
   end

   // ---------------- status bytes ----------------
   always_comb begin
      host_status           = '0;
      host_status[HB_IRQ]   = h_flag[1];
      host_status[HB_IVSW]  = h_ivsw;
      host_status[HB_CHDMA] = h_flag[0];
      host_status[HB_NVSW]  = h_nvsw;
      host_status[MSG_W-1:0] = h_msg;

      cop_status            = '0;
      cop_status[CB_IRQ]    = c_flag[3];
      cop_status[CB_TIMER]  = c_flag[2];
      cop_status[CB_DMA]    = c_flag[1];
      cop_status[CB_NMI]    = c_flag[0];
      cop_status[MSG_W-1:0] = c_msg;
   end

   // R10: the host line only falls once both host flags read clear
   p_fall_clean_r10: assert property (@(posedge clk) disable iff (rst)
      $fell(host_irq) |-> !host_status[HB_IRQ] && !host_status[HB_CHDMA]);
   // R11: an NMI request always has its flag visible
   p_nmi_flag_r11: assert property (@(posedge clk) disable iff (rst)
      cop_nmi |-> cop_status[CB_NMI]);
   // R11: an IRQ request always has some IRQ-class flag visible
   p_irq_flag_r11: assert property (@(posedge clk) disable iff (rst)
      cop_irq |-> (cop_status[CB_IRQ] || cop_status[CB_TIMER] || cop_status[CB_DMA]));
   // R2: a control write carrying the NMI bit shows the flag next cycle
   p_ctrl_nmi_r2: assert property (@(posedge clk) disable iff (rst)
      we_cop_ctrl && wr_data[CB_NMI] |=> cop_status[CB_NMI]);

endmodule

// File: tb/test_ipc_irq_ctrl.sv
module test_ipc_irq_ctrl;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       chdma_done = 1'b0;
   logic       timer_evt = 1'b0;
   logic       dma_evt = 1'b0;
   logic [7:0] host_status, cop_status;
   logic       host_irq, cop_irq, cop_nmi;

   always #(CLK_PERIOD/2) clk = ~clk;

   ipc_irq_ctrl i_ipc_irq_ctrl (
      .clk         (clk),
      .rst         (rst),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .chdma_done  (chdma_done),
      .timer_evt   (timer_evt),
      .dma_evt     (dma_evt),
      .host_status (host_status),
      .cop_status  (cop_status),
      .host_irq    (host_irq),
      .cop_irq     (cop_irq),
      .cop_nmi     (cop_nmi)
   );

   typedef struct packed {
      logic [7:0] hs;
      logic [7:0] cs;
      logic       hi;
      logic       ci;
      logic       cn;
   } exp_t;

   exp_t  exp_q[$];
   string req_q[$];
   int    n_checks = 0;
   int    n_fails  = 0;

   // reference state, from the requirements
   bit       m_hirq, m_hch, m_ivsw, m_nvsw, m_hen_irq, m_hen_ch, m_line;
   bit [3:0] m_hmsg;
   bit [3:0] m_cf;     // {irq, timer, dma, nmi}
   bit [3:0] m_cen;
   bit [3:0] m_cmsg;

   task automatic step(input bit r, input bit we, input logic [2:0] a,
                       input logic [7:0] d, input bit ch, input bit tm,
                       input bit dm, input string req);
      bit   n_hirq, n_hch, raise, drop;
      bit [3:0] n_cf;
      exp_t e;
      @(negedge clk);
      rst = r; wr_en = we; wr_addr = a; wr_data = d;
      chdma_done = ch; timer_evt = tm; dma_evt = dm;
      if (r) begin
         {m_hirq, m_hch, m_ivsw, m_nvsw, m_hen_irq, m_hen_ch, m_line} = '0;
         m_hmsg = '0; m_cf = '0; m_cen = '0; m_cmsg = '0;
      end else begin
         // host flags: R3 raise, R7 clear, R6 event wins
         n_hirq = m_hirq;
         n_hch  = m_hch;
         if (we && a == 3'd2 && d[7]) n_hirq = 1'b0;
         if (we && a == 3'd2 && d[5]) n_hch  = 1'b0;
         if (we && a == 3'd3 && d[7]) n_hirq = 1'b1;
         if (ch) n_hch = 1'b1;
         // coprocessor flags: R7 clear then R2/R6 raise
         n_cf = m_cf;
         if (we && a == 3'd5) n_cf = n_cf & ~d[7:4];
         if (we && a == 3'd0 && d[7]) n_cf[3] = 1'b1;
         if (we && a == 3'd0 && d[4]) n_cf[0] = 1'b1;
         if (tm) n_cf[2] = 1'b1;
         if (dm) n_cf[1] = 1'b1;
         // host line: R8, R9, R10
         raise = (we && a == 3'd3 && d[7] && m_hen_irq) || (ch && m_hen_ch) ||
                 (we && a == 3'd1 && d[7] && !m_hen_irq && n_hirq) ||
                 (we && a == 3'd1 && d[5] && !m_hen_ch && n_hch);
         drop  = we && a == 3'd2 && !n_hirq && !n_hch;
         if (raise)     m_line = 1'b1;
         else if (drop) m_line = 1'b0;
         m_hirq = n_hirq; m_hch = n_hch; m_cf = n_cf;
         // R12 enables
         if (we && a == 3'd1) begin m_hen_irq = d[7]; m_hen_ch = d[5]; end
         if (we && a == 3'd4) m_cen = d[7:4];
         // messages and switches
         if (we && a == 3'd3) begin m_ivsw = d[6]; m_nvsw = d[4]; m_hmsg = d[3:0]; end
         if (we && a == 3'd0) m_cmsg = d[3:0];
      end
      e.hs = {m_hirq, m_ivsw, m_hch, m_nvsw, m_hmsg};   // R4 layout
      e.cs = {m_cf, m_cmsg};                             // R5 layout
      e.hi = m_line;
      e.ci = |(m_cf[3:1] & m_cen[3:1]);                  // R11
      e.cn = m_cf[0] & m_cen[0];
      exp_q.push_back(e);
      req_q.push_back(req);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d, input string req);
      step(1'b0, 1'b1, a, d, 1'b0, 1'b0, 1'b0, req);
   endtask

   // monitor: compares one expected item per cycle, a quarter period after the edge
   initial begin
      forever begin
         @(posedge clk);
         #(CLK_PERIOD/4);
         if (exp_q.size() > 0) begin
            exp_t  e;
            exp_t  act;
            string rq;
            e  = exp_q.pop_front();
            rq = req_q.pop_front();
            act.hs = host_status; act.cs = cop_status;
            act.hi = host_irq; act.ci = cop_irq; act.cn = cop_nmi;
            n_checks++;
            if (act !== e) begin
               n_fails++;
               $display("FAIL %s: actual hs=%h cs=%h hirq=%b cirq=%b cnmi=%b expected hs=%h cs=%h hirq=%b cirq=%b cnmi=%b",
                        rq, act.hs, act.cs, act.hi, act.ci, act.cn,
                        e.hs, e.cs, e.hi, e.ci, e.cn);
            end
         end
      end
   end

   bit done = 1'b0;

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      step(1'b1, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, "R1 reset state");
      // coprocessor side
      wr(3'd0, 8'h95, "R2 R5 control raises irq+nmi, message");
      wr(3'd0, 8'h03, "R2 zero flag bits keep flags");
      wr(3'd4, 8'h10, "R11 nmi enable over pending flag");
      wr(3'd4, 8'h90, "R11 R12 irq enable over pending flag");
      wr(3'd5, 8'h80, "R7 clear irq flag");
      step(1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 1'b0, "R6 timer event, disabled");
      wr(3'd4, 8'h50, "R11 timer enable");
      step(1'b0, 1'b1, 3'd5, 8'h20, 1'b0, 1'b0, 1'b1, "R6 dma event beats clear");
      wr(3'd5, 8'h00, "R7 zero clear has no effect");
      wr(3'd5, 8'hF0, "R7 clear all coprocessor flags");
      // host side
      wr(3'd3, 8'hD9, "R3 R4 R9 host control, enable off");
      wr(3'd1, 8'h80, "R9 enable rise re-arms line");
      step(1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0, "R6 chdma event");
      wr(3'd2, 8'h80, "R10 one flag cleared, line held");
      wr(3'd1, 8'h00, "R10 enables off, line held");
      wr(3'd2, 8'h20, "R10 last flag cleared, line drops");
      wr(3'd1, 8'h20, "R12 chdma enable");
      step(1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0, "R8 enabled chdma raise");
      wr(3'd2, 8'hA0, "R7 R10 clear both host flags");
      wr(3'd3, 8'h00, "R3 control with zero bits");
      wr(3'd1, 8'hA0, "R12 both host enables");
      wr(3'd3, 8'h8C, "R8 enabled host irq raise");
      wr(3'd0, 8'h9A, "R2 coprocessor raise before reset");
      step(1'b1, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, "R1 reset mid-run");
      wr(3'd3, 8'h80, "R1 R9 enable cleared by reset");
      @(negedge clk);
      wr_en = 1'b0; chdma_done = 1'b0; timer_evt = 1'b0; dma_evt = 1'b0;
      while (exp_q.size() > 0) @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

endmodule